// File: doc/BRIEF.md
# HDLC Transparent Frame Transmitter

This block turns complete HDLC frames into a serial bit stream. A host writes every byte of a frame, address and control fields included, into a 64-byte transmit FIFO. The FIFO is split into two 32-byte pools. After each block of at most 32 bytes the host issues a transmit command. On the last block it also raises an end-of-message qualifier, and that last block may be short: a 76-byte frame goes in as 32, 32 and 12 bytes. The block pulses `pool_rdy` when the host may write the next block. The host can therefore refill one pool while the other is being shifted out.

On the serial side one bit leaves on every cycle that `bit_en` is high. A frame is sent as an opening flag, then the host bytes least significant bit first, then an optional inverted CRC-16 (x^16+x^12+x^5+1, preset to all ones, low byte first), then a closing flag. A zero is inserted after any five consecutive ones in the frame body. Between frames the line carries either repeated flags or continuous ones. If the FIFO runs dry before the end-of-message block arrives, the frame is aborted with eight ones and `underrun` pulses.

The control is one state machine with six states:
- FILL: sends 8-bit fill groups.
- OPEN: sends the opening flag.
- BODY: sends the host bytes.
- FCS: sends the 16 check bits.
- CLOSE: sends the closing flag.
- ABORT: sends eight ones.

Its transitions are:
- FILL→OPEN: at the end of a fill group, when committed bytes are waiting.
- OPEN→BODY: after the opening flag.
- BODY→BODY: at the end of a byte, when more committed bytes are waiting.
- BODY→FCS or BODY→CLOSE: at the end of the last byte after end-of-message, depending on the CRC switch.
- BODY→ABORT: when the FIFO is empty before end-of-message.
- FCS→CLOSE: after the 16 check bits.
- CLOSE→FILL and ABORT→FILL: at the end of those groups.
- Any state→FILL: on the reset command.

Top module: `hdlc_xparent_tx`

## Requirements
- R1: After `rst_n` is released, `tx_bit` is 1, `pool_rdy` and `underrun` are 0, and the fill is continuous ones whatever `cfg_fill_flags` says, until the first frame end or reset command.
- R2: A frame on `tx_bit` is: opening flag 8'h7E, then every committed host byte in write order with each byte's bit 0 first, then the CRC field when enabled, then closing flag 8'h7E. All flags are sent bit 0 first.
- R3: With `cfg_no_crc`=0 the CRC field is the one's complement of a CRC-16 over the host bytes. The CRC is computed bit-serially with reflected polynomial 16'h8408 and a register preset to 16'hFFFF. The field is sent low byte first, bit 0 first.
- R4: With `cfg_no_crc`=1 the closing flag follows the last host byte directly, with no CRC field.
- R5: Inside the host bytes and the CRC field, a 0 is inserted after every run of five 1s, including a run that ends at the last body bit before the closing flag. Flags, fill and abort ones get no insertion.
- R6: Fill is sent in 8-bit groups: 8'h7E per group when the latched selection is 1, all ones when it is 0.
- R7: `cfg_fill_flags` is copied into the fill selection only when a frame closes, a frame aborts, or `cmd_reset` is high. At any other time a change has no effect on `tx_bit`.
- R8: Bytes written without a following `cmd_xmit` are never sent. `cmd_xmit` commits every byte written up to and including its own cycle. A frame starts at the next fill-group boundary once committed bytes exist.
- R9: After `cmd_xmit`, `pool_rdy` pulses for exactly one cycle once the FIFO holds at most 32 bytes. If `cmd_end` accompanied that command, the pulse is held back until the frame has closed.
- R10: If a byte ends with no committed byte left and no end-of-message pending, eight 1s follow with no inserted zero. A one-cycle `underrun` pulse follows, and the line returns to fill.
- R11: `cmd_reset` empties the FIFO and drops any pending frame, end mark or pool request. From the next `bit_en` the line sends whole fill groups of the newly latched selection.
- R12: The FIFO holds 64 bytes, and writes arriving while it is full are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host byte |
| cmd_xmit | input | 1 | Transmit-block command |
| cmd_end | input | 1 | End-of-message qualifier, read with `cmd_xmit` |
| cmd_reset | input | 1 | Transmitter reset command |
| cfg_no_crc | input | 1 | 1 suppresses the CRC field |
| cfg_fill_flags | input | 1 | Fill selection: 1 flags, 0 ones |
| bit_en | input | 1 | Serial bit enable |
| tx_bit | output | 1 | Serial output |
| pool_rdy | output | 1 | Pool-ready pulse |
| underrun | output | 1 | Abort-on-underrun pulse |

## Verification
Some properties are checked by assertions on every cycle:
- The zero-insertion run counter never goes past five.
- The FIFO never overfills and never pops while empty.
- Idle fill always drives ones.
- The fill selection holds steady during the frame body.
- `underrun` only ever follows the abort state.

Other behaviour can only be shown by the bench's scenarios, which compare the captured serial stream against frames the bench builds itself:
- exact bit order, CRC values and inserted zeros;
- the deferred fill change;
- uncommitted bytes staying unsent;
- pool-ready timing around the end-of-message block;
- FIFO clearing on reset and the 64-byte limit.

// File: rtl/hdlc_tx_pkg.sv
`timescale 1ns/1ps
package hdlc_tx_pkg;

    typedef enum logic [2:0] {
        ST_FILL,
        ST_OPEN,
        ST_BODY,
        ST_FCS,
        ST_CLOSE,
        ST_ABORT
    } tx_state_e;

    localparam logic [7:0]  FLAG_PATTERN = 8'h7E;
    localparam logic [15:0] CRC_POLY_REF = 16'h8408;

endpackage

// File: rtl/hdlc_tx_fifo.sv
`timescale 1ns/1ps
module hdlc_tx_fifo #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;

    assign rd_data = mem[rptr_q];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr_q] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            count  <= '0;
        end else if (clr) begin
            wptr_q <= '0;
            rptr_q <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wptr_q <= wptr_q + 1'b1;
            if (rd_en) rptr_q <= rptr_q + 1'b1;
            count <= count + CW'(wr_en) - CW'(rd_en);
        end
    end

    // R12: storage never holds more than its depth
    a_r12_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R12: writes reaching storage only when room exists
    a_r12_no_full_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> count < CW'(DEPTH));

    // R2: the serializer never pops an empty FIFO
    a_r2_no_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> count != '0);

endmodule

// File: rtl/hdlc_tx_crc.sv
`timescale 1ns/1ps
module hdlc_tx_crc #(
    parameter int          W    = 16,
    parameter logic [W-1:0] POLY = hdlc_tx_pkg::CRC_POLY_REF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] crc_q,
    output logic [W-1:0] crc_d
);

    always_comb begin
        crc_d = crc_q;
        if (en) crc_d = (crc_q >> 1) ^ ((crc_q[0] ^ din) ? POLY : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    crc_q <= '1;
        else if (init) crc_q <= '1;
        else           crc_q <= crc_d;
    end

endmodule

// File: rtl/hdlc_xparent_tx.sv
`timescale 1ns/1ps
module hdlc_xparent_tx
    import hdlc_tx_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int POOL  = 32,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          cmd_xmit,
    input  logic          cmd_end,
    input  logic          cmd_reset,
    input  logic          cfg_no_crc,
    input  logic          cfg_fill_flags,
    input  logic          bit_en,
    output logic          tx_bit,
    output logic          pool_rdy,
    output logic          underrun
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int FW = 16;
    localparam int BW = $clog2(FW);

    tx_state_e     state_q, state_d;
    logic [BW-1:0] bcnt_q;
    logic [FW-1:0] sh_q;
    logic [2:0]    ones_q;
    logic          fill_sel_q, eom_q, pend_q, tx_q, pool_q, urun_q;
    logic [CW-1:0] ucnt_q, count, avail;
    logic [DW-1:0] rd_data;
    logic [FW-1:0] crc_q, crc_d;
    logic          body_bits, stuff, grp_end, adv, fin, have, pop;
    logic          frame_done, wr_acc, pool_fire, nbit;

    assign avail     = count - ucnt_q;
    assign have      = avail != '0;
    assign wr_acc    = wr_en && !cmd_reset && (count < CW'(DEPTH));
    assign pool_fire = pend_q && (count <= CW'(POOL)) && !eom_q;

    hdlc_tx_fifo #(.DEPTH(DEPTH), .DW(DW)) fifo_i (
        .clk(clk), .rst_n(rst_n), .clr(cmd_reset),
        .wr_en(wr_acc), .wr_data(wr_data),
        .rd_en(pop), .rd_data(rd_data), .count(count)
    );

    hdlc_tx_crc #(.W(FW)) crc_i (
        .clk(clk), .rst_n(rst_n),
        .init(cmd_reset || state_q == ST_OPEN),
        .en(adv && state_q == ST_BODY), .din(sh_q[0]),
        .crc_q(crc_q), .crc_d(crc_d)
    );

    // next-state logic
    always_comb begin
        body_bits  = (state_q == ST_BODY) || (state_q == ST_FCS);
        stuff      = (body_bits || state_q == ST_CLOSE) && ones_q == 3'd5;
        grp_end    = (state_q == ST_FCS) ? (bcnt_q == BW'(FW - 1)) : (bcnt_q == BW'(7));
        adv        = bit_en && !cmd_reset && !stuff;
        fin        = adv && grp_end;
        pop        = fin && ((state_q == ST_OPEN) || (state_q == ST_BODY && have));
        frame_done = fin && ((state_q == ST_CLOSE) || (state_q == ST_ABORT));
        state_d    = state_q;
        if (cmd_reset) begin
            state_d = ST_FILL;
        end else if (fin) begin
            unique case (state_q)
                ST_FILL:  if (have) state_d = ST_OPEN;
                ST_OPEN:  state_d = ST_BODY;
                ST_BODY:  if (!have) state_d = eom_q ? (cfg_no_crc ? ST_CLOSE : ST_FCS) : ST_ABORT;
                ST_FCS:   state_d = ST_CLOSE;
                ST_CLOSE: state_d = ST_FILL;
                ST_ABORT: state_d = ST_FILL;
                default:  state_d = ST_FILL;
            endcase
        end
    end

    // next serial bit
    always_comb begin
        unique case (state_q)
            ST_FILL:          nbit = fill_sel_q ? FLAG_PATTERN[bcnt_q[2:0]] : 1'b1;
            ST_OPEN:          nbit = FLAG_PATTERN[bcnt_q[2:0]];
            ST_BODY, ST_FCS:  nbit = stuff ? 1'b0 : sh_q[0];
            ST_CLOSE:         nbit = stuff ? 1'b0 : FLAG_PATTERN[bcnt_q[2:0]];
            ST_ABORT:         nbit = 1'b1;
            default:          nbit = 1'b1;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FILL;
        else        state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt_q     <= '0;
            sh_q       <= '0;
            ones_q     <= '0;
            fill_sel_q <= 1'b0;
            eom_q      <= 1'b0;
            pend_q     <= 1'b0;
            ucnt_q     <= '0;
            tx_q       <= 1'b1;
            pool_q     <= 1'b0;
            urun_q     <= 1'b0;
        end else begin
            pool_q <= pool_fire && !cmd_reset;
            urun_q <= frame_done && state_q == ST_ABORT;
            if (cmd_reset) begin
                bcnt_q     <= '0;
                sh_q       <= '0;
                ones_q     <= '0;
                fill_sel_q <= cfg_fill_flags;
                eom_q      <= 1'b0;
                pend_q     <= 1'b0;
                ucnt_q     <= '0;
                tx_q       <= 1'b1;
            end else begin
                if (frame_done) begin
                    eom_q      <= 1'b0;
                    fill_sel_q <= cfg_fill_flags;
                end
                if (cmd_xmit) begin
                    ucnt_q <= '0;
                    pend_q <= 1'b1;
                    if (cmd_end) eom_q <= 1'b1;
                end else begin
                    if (wr_acc)    ucnt_q <= ucnt_q + 1'b1;
                    if (pool_fire) pend_q <= 1'b0;
                end
                if (bit_en) begin
                    tx_q <= nbit;
                    if (stuff) begin
                        ones_q <= '0;
                    end else begin
                        bcnt_q <= grp_end ? '0 : bcnt_q + 1'b1;
                        ones_q <= (body_bits && sh_q[0]) ? ones_q + 1'b1 : 3'd0;
                        if (pop)
                            sh_q <= {{(FW-DW){1'b0}}, rd_data};
                        else if (state_q == ST_BODY && state_d == ST_FCS)
                            sh_q <= ~crc_d;
                        else if (body_bits)
                            sh_q <= sh_q >> 1;
                    end
                end
            end
        end
    end

    assign tx_bit   = tx_q;
    assign pool_rdy = pool_q;
    assign underrun = urun_q;

    // R5: never more than five ones in a body run
    a_r5_run_limit: assert property (@(posedge clk) disable iff (!rst_n)
        ones_q <= 3'd5);

    // R10: underrun pulses only after the abort state
    a_r10_underrun_src: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> $past(state_q) == ST_ABORT);

    // R7: fill selection untouched during the frame body
    a_r7_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BODY && !cmd_reset) |=> $stable(fill_sel_q));

    // R6: idle fill drives ones
    a_r6_idle_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !cmd_reset && state_q == ST_FILL && !fill_sel_q) |=> tx_bit);

endmodule

// File: tb/hdlc_xparent_tx_tb_top.sv
`timescale 1ns/1ps
module hdlc_xparent_tx_tb_top;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n, wr_en, cmd_xmit, cmd_end, cmd_reset;
    logic       cfg_no_crc, cfg_fill_flags, bit_en;
    logic [7:0] wr_data;
    logic       tx_bit, pool_rdy, underrun;

    hdlc_xparent_tx dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cmd_xmit(cmd_xmit), .cmd_end(cmd_end), .cmd_reset(cmd_reset),
        .cfg_no_crc(cfg_no_crc), .cfg_fill_flags(cfg_fill_flags),
        .bit_en(bit_en), .tx_bit(tx_bit), .pool_rdy(pool_rdy), .underrun(underrun)
    );

    int   n_chk = 0, n_err = 0, cyc = 0, ur_cnt = 0, pr_wide = 0;
    bit   be_hold = 1'b1, be_seen = 1'b0, pr_prev = 1'b0, done = 1'b0;
    bit   cap[$];
    bit   exp_q[$];
    logic [7:0] dat_q[$];

    always @(posedge clk) be_seen <= bit_en;
    always @(negedge clk) begin
        if (be_seen && rst_n) cap.push_back(tx_bit);
        if (underrun) ur_cnt++;
        if (pool_rdy && pr_prev) pr_wide++;
        pr_prev = pool_rdy;
    end
    always @(negedge clk) bit_en <= be_hold ? 1'b0 : ($urandom % 3 != 0);

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            n_chk++; n_err++;
            $display("FAIL R2 watchdog expired actual=%0d expected<%0d", cyc, 190000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) r = (r >> 1) ^ ((r[0] ^ b[i]) ? 16'h8408 : 16'h0);
        return r;
    endfunction

    function automatic void push_raw(input logic [7:0] b);
        for (int i = 0; i < 8; i++) exp_q.push_back(b[i]);
    endfunction

    function automatic int body_byte(input logic [7:0] b, input int run);
        int r = run;
        for (int i = 0; i < 8; i++) begin
            if (r == 5) begin exp_q.push_back(1'b0); r = 0; end
            exp_q.push_back(b[i]);
            r = b[i] ? r + 1 : 0;
        end
        return r;
    endfunction

    function automatic void build_frame(input bit ncrc, input bit abrt);
        int run = 0;
        logic [15:0] c = 16'hFFFF;
        exp_q.delete();
        push_raw(8'h7E);
        foreach (dat_q[i]) begin
            c   = crc_byte(c, dat_q[i]);
            run = body_byte(dat_q[i], run);
        end
        if (abrt) begin
            push_raw(8'hFF);
        end else begin
            if (!ncrc) begin
                c   = ~c;
                run = body_byte(c[7:0], run);
                run = body_byte(c[15:8], run);
            end
            if (run == 5) exp_q.push_back(1'b0);
            push_raw(8'h7E);
        end
    endfunction

    function automatic void push_fill(input bit flags, input int groups);
        for (int g = 0; g < groups; g++) push_raw(flags ? 8'h7E : 8'hFF);
    endfunction

    function automatic int find(input int from);
        for (int i = from; i + exp_q.size() <= cap.size(); i++) begin
            bit m = 1'b1;
            for (int j = 0; j < exp_q.size(); j++)
                if (cap[i+j] != exp_q[j]) begin m = 1'b0; break; end
            if (m) return i;
        end
        return -1;
    endfunction

    function automatic int count_zeros(input int from);
        int z = 0;
        for (int i = from; i < cap.size(); i++) if (!cap[i]) z++;
        return z;
    endfunction

    task automatic wait_bits(input int n);
        int t = cap.size() + n;
        while (cap.size() < t) @(negedge clk);
    endtask

    task automatic host_write(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic host_cmd(input bit last);
        cmd_xmit = 1'b1; cmd_end = last;
        @(negedge clk);
        cmd_xmit = 1'b0; cmd_end = 1'b0;
    endtask

    task automatic wait_pool(output bit got);
        got = 1'b0;
        for (int i = 0; i < 30000; i++) begin
            if (pool_rdy) begin got = 1'b1; break; end
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic send_frame(input bit ncrc);
        int pos = 0;
        int n;
        bit last, got;
        cfg_no_crc = ncrc;
        while (pos < dat_q.size()) begin
            n = dat_q.size() - pos;
            if (n > 32) n = 32;
            for (int k = 0; k < n; k++) host_write(dat_q[pos+k]);
            pos += n;
            last = (pos >= dat_q.size());
            host_cmd(last);
            wait_pool(got);
            chk(got, "R9", "pool_rdy after block seen", int'(got), 1);
        end
    endtask

    task automatic check_frame(input string req, input bit ncrc, input bit abrt,
                               input bit fill_flags, input int mark);
        int idx;
        wait_bits(24);
        build_frame(ncrc, abrt);
        push_fill(fill_flags, 2);
        idx = find(mark);
        chk(idx >= 0, req, "expected frame bits present in stream", idx >= 0, 1);
    endtask

    task automatic rand_data(input int len);
        dat_q.delete();
        for (int i = 0; i < len; i++) dat_q.push_back(8'($urandom));
    endtask

    initial begin
        int mark, len, z, seen;
        bit ncrc, got;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; cmd_xmit = 1'b0; cmd_end = 1'b0;
        cmd_reset = 1'b0; cfg_no_crc = 1'b0; cfg_fill_flags = 1'b1;
        repeat (5) @(negedge clk);
        chk(tx_bit == 1'b1, "R1", "tx_bit in reset", int'(tx_bit), 1);
        chk(pool_rdy == 1'b0, "R1", "pool_rdy in reset", int'(pool_rdy), 0);
        chk(underrun == 1'b0, "R1", "underrun in reset", int'(underrun), 0);
        rst_n = 1'b1;
        be_hold = 1'b0;

        // R1, R7: fill stays ones although flags are selected
        mark = cap.size();
        wait_bits(40);
        z = count_zeros(mark);
        chk(z == 0, "R1", "zeros in fill before first frame", z, 0);

        // R2, R3: first frame, flags take effect after it
        rand_data(20);
        mark = cap.size();
        send_frame(1'b0);
        check_frame("R2 R3 R7", 1'b0, 1'b0, 1'b1, mark);

        // random frames across block boundaries (R2, R3, R4)
        for (int f = 0; f < 6; f++) begin
            len  = 1 + ($urandom % 80);
            ncrc = ($urandom % 2) == 1;
            rand_data(len);
            mark = cap.size();
            send_frame(ncrc);
            check_frame(ncrc ? "R4" : "R3", ncrc, 1'b0, 1'b1, mark);
        end

        // R5: bit insertion heavy content, including run at the end
        dat_q = '{8'hFF, 8'hFF, 8'h7E, 8'h3E, 8'hF8, 8'h1F, 8'hFF, 8'h7C};
        mark = cap.size();
        send_frame(1'b1);
        check_frame("R5", 1'b1, 1'b0, 1'b1, mark);
        dat_q = '{8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hFF};
        mark = cap.size();
        send_frame(1'b0);
        check_frame("R5", 1'b0, 1'b0, 1'b1, mark);

        // R7: changed selection defers while idle, applies after next frame
        cfg_fill_flags = 1'b0;
        mark = cap.size();
        wait_bits(24);
        exp_q.delete(); push_raw(8'h7E);
        chk(find(mark) >= 0, "R7", "flags still sent after selection change", find(mark) >= 0, 1);
        rand_data(40);
        mark = cap.size();
        send_frame(1'b0);
        check_frame("R6 R7", 1'b0, 1'b0, 1'b0, mark);

        // R8: uncommitted bytes are not sent
        rand_data(4);
        mark = cap.size();
        foreach (dat_q[i]) host_write(dat_q[i]);
        wait_bits(100);
        z = count_zeros(mark);
        chk(z == 0, "R8", "zeros while bytes uncommitted", z, 0);
        host_cmd(1'b1);
        wait_pool(got);
        chk(got, "R9", "pool_rdy after frame close", int'(got), 1);
        check_frame("R8", 1'b0, 1'b0, 1'b0, mark);

        // R10: underrun abort
        rand_data(5);
        seen = ur_cnt;
        mark = cap.size();
        foreach (dat_q[i]) host_write(dat_q[i]);
        host_cmd(1'b0);
        for (int i = 0; i < 5000 && ur_cnt == seen; i++) @(negedge clk);
        chk(ur_cnt == seen + 1, "R10", "underrun pulse count", ur_cnt - seen, 1);
        check_frame("R10", 1'b0, 1'b1, 1'b0, mark);

        // R12: 70 writes, only 64 kept
        cfg_fill_flags = 1'b1;
        rand_data(70);
        mark = cap.size();
        foreach (dat_q[i]) host_write(dat_q[i]);
        dat_q = dat_q[0:63];
        host_cmd(1'b1);
        wait_pool(got);
        chk(got, "R9", "pool_rdy after full frame", int'(got), 1);
        check_frame("R12", 1'b0, 1'b0, 1'b1, mark);

        // R11: reset command mid-frame
        cfg_fill_flags = 1'b0;
        rand_data(60);
        for (int k = 0; k < 32; k++) host_write(dat_q[k]);
        host_cmd(1'b0);
        wait_pool(got);
        for (int k = 32; k < 60; k++) host_write(dat_q[k]);
        wait_bits(100);
        be_hold = 1'b1;
        @(negedge clk); @(negedge clk);
        cmd_reset = 1'b1;
        @(negedge clk);
        cmd_reset = 1'b0;
        chk(tx_bit == 1'b1, "R11", "tx_bit after reset command", int'(tx_bit), 1);
        mark = cap.size();
        be_hold = 1'b0;
        wait_bits(24);
        z = count_zeros(mark);
        chk(z == 0, "R11", "zeros in new ones fill after reset", z, 0);
        rand_data(3);
        mark = cap.size();
        send_frame(1'b0);
        check_frame("R11", 1'b0, 1'b0, 1'b0, mark);

        chk(ur_cnt == 1, "R10", "total underrun pulses", ur_cnt, 1);
        chk(pr_wide == 0, "R9", "pool_rdy pulses longer than one cycle", pr_wide, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule